// File: doc/BRIEF.md
# Paged Branch and Call Sequencer

This block steers the program counter of a small core that fetches 12-bit instructions and works on 4-bit data. The counter has three fields: a bank, a 4-bit page and an 8-bit step inside the page. Software first places the target bank and page in pending registers outside this block. A branch instruction then moves those staged values into the counter and takes the new step from the opcode's low byte. Every other instruction only advances the step by one. When the step rolls over, the page does not move.

The block recognises five opcode groups. These are the unconditional jump, four flag-conditioned jumps, a subroutine call, a call whose target page is zero, and a return that also stores an 8-bit immediate. Calls push the return address as three nibbles through a single-port nibble memory, addressed from an 8-bit stack pointer. The return pops the same three nibbles. It writes the immediate as two nibbles at the data index X and X+1, and it hands X+2 back to the index register. Each branch keeps `busy` high for its full cycle count so that fetch stalls until the sequence ends. The block never changes a flag.

Top module: `bs_branch_seq`

## Requirements
- R1: While and after reset, until the first instruction, busy, mem_we, mem_re and x_adv are 0, and pc_bank, pc_page and pc_step are 0. sp equals the parameter SP_INIT, which defaults to 0.
- R2: An accepted opcode whose top nibble is 8 to F is a plain instruction. busy stays low. On the next edge pc_step becomes pc_step+1 modulo 256, so 0xFF goes to 0x00. pc_page, pc_bank and sp keep their values, and the pending bank and page are not used.
- R3: Top nibble 0 is a jump. busy is high for exactly 5 cycles, starting the cycle after op_valid. At the end, pc_bank takes pend_bank, pc_page takes pend_page, and pc_step takes opcode[7:0].
- R4: Top nibbles 2, 3, 6 and 7 jump as in R3 only when, respectively, flag_c=1, flag_c=0, flag_z=1 or flag_z=0. The flags are sampled in the op_valid cycle. When the jump is not taken, pc_step advances by one and page and bank are kept. Either way busy lasts 5 cycles.
- R5: Top nibble 4 is a call and takes 7 busy cycles. Let RA be pc_step+1 modulo 256. In busy cycles 1, 2 and 3 the block writes, in that order, pc_page to SP-1, RA[7:4] to SP-2 and RA[3:0] to SP-3. At the end sp drops by 3 and the counter jumps as in R3.
- R6: Top nibble 5 performs the same push and timing as R5. pc_page becomes 0 and pc_bank takes pend_bank.
- R7: Top nibble 1 is a return and takes 12 busy cycles. It issues reads of SP, SP+1 and SP+2 in busy cycles 1, 2 and 3, and the memory returns data on the cycle after each read strobe. At the end pc_step = {M(SP+1), M(SP)} and pc_page = M(SP+2), pc_bank is unchanged, and sp rises by 3.
- R8: The return writes opcode[3:0] to X in busy cycle 4 and opcode[7:4] to X+1 in busy cycle 5. X is x_ptr sampled with op_valid. In the last busy cycle x_adv is 1 and x_next = X+2 modulo 256.
- R9: op_valid is ignored while busy is high.
- R10: sp, the stack addresses and the X addresses all wrap modulo 256.
- R11: pc fields and sp do not change while busy is high. They change only at the edge that ends the last busy cycle. Memory strobes appear only while busy, and never both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A fetched opcode is presented this cycle |
| opcode | input | 12 | Fetched instruction word |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| pend_bank | input | BANK_W (1) | Staged bank for the next branch |
| pend_page | input | 4 | Staged page for the next branch |
| x_ptr | input | SP_W (8) | Current data index X |
| mem_rdata | input | 4 | Nibble read data, one cycle after mem_re |
| busy | output | 1 | Branch sequence in progress; fetch must stall |
| pc_bank | output | BANK_W (1) | Program counter bank |
| pc_page | output | 4 | Program counter page |
| pc_step | output | 8 | Program counter step |
| sp | output | SP_W (8) | Stack pointer |
| mem_addr | output | SP_W (8) | Nibble memory address |
| mem_re | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 4 | Write data |
| x_adv | output | 1 | Load x_next into the index register |
| x_next | output | SP_W (8) | New index value X+2 |

## Verification
A wrong sequence counter or length shows up at once as a wrong number of busy cycles after op_valid. It also misplaces the memory strobes, which a nibble memory in the bench exposes through the address and order of writes within that same instruction. An error in a captured pending value, flag or return nibble stays hidden until busy falls, when the counter fields show the wrong target. A corrupted stack pointer can pass a single call unnoticed. It shows only on the later return, which pops the wrong nibbles, so the calls and returns are tested as nested pairs that cross the 0xFF/0x00 boundary.

// File: rtl/bs_pkg.sv
package bs_pkg;
  localparam int NIB_W  = 4;
  localparam int STEP_W = 8;
  localparam int OPC_W  = 12;
  localparam int CNT_W  = 4;

  localparam int LEN_JUMP = 5;
  localparam int LEN_CALL = 7;
  localparam int LEN_RETD = 12;

  typedef enum logic [2:0] {
    GRP_NONE,
    GRP_JUMP,
    GRP_CALL,
    GRP_CALZ,
    GRP_RETD
  } grp_e;

  function automatic logic [CNT_W-1:0] seq_len(grp_e g);
    case (g)
      GRP_JUMP:          seq_len = CNT_W'(LEN_JUMP);
      GRP_CALL, GRP_CALZ: seq_len = CNT_W'(LEN_CALL);
      GRP_RETD:          seq_len = CNT_W'(LEN_RETD);
      default:           seq_len = CNT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/bs_decode.sv
module bs_decode
  import bs_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic             cond_c,
  input  logic             cond_z,
  output grp_e             grp,
  output logic             taken
);
  logic [3:0] major;
  assign major = opcode[OPC_W-1 -: 4];

  always_comb begin
    grp   = GRP_NONE;
    taken = 1'b0;
    case (major)
      4'h0: begin grp = GRP_JUMP; taken = 1'b1;    end
      4'h1: begin grp = GRP_RETD; taken = 1'b1;    end
      4'h2: begin grp = GRP_JUMP; taken = cond_c;  end
      4'h3: begin grp = GRP_JUMP; taken = !cond_c; end
      4'h4: begin grp = GRP_CALL; taken = 1'b1;    end
      4'h5: begin grp = GRP_CALZ; taken = 1'b1;    end
      4'h6: begin grp = GRP_JUMP; taken = cond_z;  end
      4'h7: begin grp = GRP_JUMP; taken = !cond_z; end
      default: begin grp = GRP_NONE; taken = 1'b0; end
    endcase
  end
endmodule

// File: rtl/bs_seq_ctl.sv
module bs_seq_ctl
  import bs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  grp_e             grp,
  output logic             accept,
  output logic             busy,
  output logic             last,
  output logic [CNT_W-1:0] cnt
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] len_q, len_d;

  assign accept = op_valid && !busy_q && (grp != GRP_NONE);
  assign last   = busy_q && (cnt_q == len_q - CNT_W'(1));
  assign busy   = busy_q;
  assign cnt    = cnt_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      len_d  = seq_len(grp);
    end else if (last) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      len_q  <= CNT_W'(1);
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
    end
  end
endmodule

// File: rtl/bs_stack_port.sv
module bs_stack_port
  import bs_pkg::*;
#(
  parameter int SP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  grp_e              grp_q,
  input  logic              busy,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [SP_W-1:0]   sp_q,
  input  logic [SP_W-1:0]   x_q,
  input  logic [STEP_W-1:0] ret_step,
  input  logic [NIB_W-1:0]  cur_page,
  input  logic [STEP_W-1:0] imm,
  input  logic [NIB_W-1:0]  mem_rdata,
  output logic [SP_W-1:0]   mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [NIB_W-1:0]  mem_wdata,
  output logic [STEP_W-1:0] pop_step,
  output logic [NIB_W-1:0]  pop_page
);
  localparam logic [SP_W-1:0] ONE   = SP_W'(1);
  localparam logic [SP_W-1:0] TWO   = SP_W'(2);
  localparam logic [SP_W-1:0] THREE = SP_W'(3);

  logic is_push, is_pop;
  assign is_push = busy && (grp_q == GRP_CALL || grp_q == GRP_CALZ);
  assign is_pop  = busy && (grp_q == GRP_RETD);

  always_comb begin
    mem_addr  = sp_q;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = '0;
    if (is_push) begin
      case (cnt)
        CNT_W'(0): begin mem_addr = sp_q - ONE;   mem_we = 1'b1; mem_wdata = cur_page;      end
        CNT_W'(1): begin mem_addr = sp_q - TWO;   mem_we = 1'b1; mem_wdata = ret_step[7:4]; end
        CNT_W'(2): begin mem_addr = sp_q - THREE; mem_we = 1'b1; mem_wdata = ret_step[3:0]; end
        default: ;
      endcase
    end else if (is_pop) begin
      case (cnt)
        CNT_W'(0): begin mem_addr = sp_q;        mem_re = 1'b1; end
        CNT_W'(1): begin mem_addr = sp_q + ONE;  mem_re = 1'b1; end
        CNT_W'(2): begin mem_addr = sp_q + TWO;  mem_re = 1'b1; end
        CNT_W'(3): begin mem_addr = x_q;         mem_we = 1'b1; mem_wdata = imm[3:0]; end
        CNT_W'(4): begin mem_addr = x_q + ONE;   mem_we = 1'b1; mem_wdata = imm[7:4]; end
        default: ;
      endcase
    end
  end

  // read data arrives one cycle after each read strobe
  logic             cap_lo, cap_hi, cap_pg;
  logic [NIB_W-1:0] lo_q, lo_d, hi_q, hi_d, pg_q, pg_d;

  assign cap_lo = is_pop && (cnt == CNT_W'(1));
  assign cap_hi = is_pop && (cnt == CNT_W'(2));
  assign cap_pg = is_pop && (cnt == CNT_W'(3));

  always_comb begin
    lo_d = cap_lo ? mem_rdata : lo_q;
    hi_d = cap_hi ? mem_rdata : hi_q;
    pg_d = cap_pg ? mem_rdata : pg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
      pg_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
      pg_q <= pg_d;
    end
  end

  assign pop_step = {hi_q, lo_q};
  assign pop_page = pg_q;
endmodule

// File: rtl/bs_branch_seq.sv
module bs_branch_seq
  import bs_pkg::*;
#(
  parameter int              BANK_W  = 1,
  parameter int              SP_W    = 8,
  parameter logic [SP_W-1:0] SP_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [11:0]       opcode,
  input  logic              flag_c,
  input  logic              flag_z,
  input  logic [BANK_W-1:0] pend_bank,
  input  logic [3:0]        pend_page,
  input  logic [SP_W-1:0]   x_ptr,
  input  logic [3:0]        mem_rdata,
  output logic              busy,
  output logic [BANK_W-1:0] pc_bank,
  output logic [3:0]        pc_page,
  output logic [7:0]        pc_step,
  output logic [SP_W-1:0]   sp,
  output logic [SP_W-1:0]   mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [3:0]        mem_wdata,
  output logic              x_adv,
  output logic [SP_W-1:0]   x_next
);
  localparam logic [SP_W-1:0]   SP_DELTA = SP_W'(3);
  localparam logic [SP_W-1:0]   X_DELTA  = SP_W'(2);
  localparam logic [STEP_W-1:0] STEP_ONE = STEP_W'(1);

  grp_e             dec_grp;
  logic             dec_taken;
  logic             accept, last;
  logic [CNT_W-1:0] cnt;

  bs_decode u_dec (
    .opcode (opcode),
    .cond_c (flag_c),
    .cond_z (flag_z),
    .grp    (dec_grp),
    .taken  (dec_taken)
  );

  bs_seq_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .grp      (dec_grp),
    .accept   (accept),
    .busy     (busy),
    .last     (last),
    .cnt      (cnt)
  );

  // operands captured when a branch is accepted
  grp_e              grp_q, grp_d;
  logic              taken_q, taken_d;
  logic [STEP_W-1:0] imm_q, imm_d;
  logic [BANK_W-1:0] nbank_q, nbank_d;
  logic [NIB_W-1:0]  npage_q, npage_d;
  logic [SP_W-1:0]   x_q, x_d;

  always_comb begin
    grp_d   = grp_q;
    taken_d = taken_q;
    imm_d   = imm_q;
    nbank_d = nbank_q;
    npage_d = npage_q;
    x_d     = x_q;
    if (accept) begin
      grp_d   = dec_grp;
      taken_d = dec_taken;
      imm_d   = opcode[STEP_W-1:0];
      nbank_d = pend_bank;
      npage_d = pend_page;
      x_d     = x_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q   <= GRP_NONE;
      taken_q <= 1'b0;
      imm_q   <= '0;
      nbank_q <= '0;
      npage_q <= '0;
      x_q     <= '0;
    end else begin
      grp_q   <= grp_d;
      taken_q <= taken_d;
      imm_q   <= imm_d;
      nbank_q <= nbank_d;
      npage_q <= npage_d;
      x_q     <= x_d;
    end
  end

  // program counter and stack pointer
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [NIB_W-1:0]  page_q, page_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [SP_W-1:0]   sp_q, sp_d;
  logic [STEP_W-1:0] step_inc;
  logic [STEP_W-1:0] pop_step;
  logic [NIB_W-1:0]  pop_page;
  logic              plain;

  assign step_inc = step_q + STEP_ONE;
  assign plain    = op_valid && !busy && (dec_grp == GRP_NONE);

  bs_stack_port #(.SP_W(SP_W)) u_stk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp_q     (grp_q),
    .busy      (busy),
    .cnt       (cnt),
    .sp_q      (sp_q),
    .x_q       (x_q),
    .ret_step  (step_inc),
    .cur_page  (page_q),
    .imm       (imm_q),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .pop_step  (pop_step),
    .pop_page  (pop_page)
  );

  always_comb begin
    bank_d = bank_q;
    page_d = page_q;
    step_d = step_q;
    sp_d   = sp_q;
    if (plain) begin
      step_d = step_inc;
    end else if (last) begin
      case (grp_q)
        GRP_JUMP: begin
          if (taken_q) begin
            bank_d = nbank_q;
            page_d = npage_q;
            step_d = imm_q;
          end else begin
            step_d = step_inc;
          end
        end
        GRP_CALL: begin
          bank_d = nbank_q;
          page_d = npage_q;
          step_d = imm_q;
          sp_d   = sp_q - SP_DELTA;
        end
        GRP_CALZ: begin
          bank_d = nbank_q;
          page_d = '0;
          step_d = imm_q;
          sp_d   = sp_q - SP_DELTA;
        end
        GRP_RETD: begin
          page_d = pop_page;
          step_d = pop_step;
          sp_d   = sp_q + SP_DELTA;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      page_q <= '0;
      step_q <= '0;
      sp_q   <= SP_INIT;
    end else begin
      bank_q <= bank_d;
      page_q <= page_d;
      step_q <= step_d;
      sp_q   <= sp_d;
    end
  end

  assign pc_bank = bank_q;
  assign pc_page = page_q;
  assign pc_step = step_q;
  assign sp      = sp_q;
  assign x_adv   = last && (grp_q == GRP_RETD);
  assign x_next  = x_q + X_DELTA;
endmodule

// File: rtl/bs_branch_seq_chk.sv
module bs_branch_seq_chk #(
  parameter int BANK_W = 1,
  parameter int SP_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_we,
  input logic              mem_re,
  input logic              x_adv,
  input logic [BANK_W-1:0] pc_bank,
  input logic [3:0]        pc_page,
  input logic [7:0]        pc_step,
  input logic [SP_W-1:0]   sp
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R11

  AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> busy); // R11

  AST_PC_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && busy) |=> (!busy || $stable({pc_bank, pc_page, pc_step}))); // R11

  AST_SP_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !busy) |=> $stable(sp)); // R2

  AST_SP_STEP_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (sp != $past(sp))) |->
      ((sp == $past(sp) + SP_W'(3)) || (sp == $past(sp) - SP_W'(3)))); // R10

  AST_XADV_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    x_adv |-> busy); // R8
endmodule

bind bs_branch_seq bs_branch_seq_chk #(.BANK_W(BANK_W), .SP_W(SP_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .mem_we  (mem_we),
  .mem_re  (mem_re),
  .x_adv   (x_adv),
  .pc_bank (pc_bank),
  .pc_page (pc_page),
  .pc_step (pc_step),
  .sp      (sp)
);

// File: tb/bs_branch_seq_tb.sv
module bs_branch_seq_tb;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [11:0] opcode;
  logic       flag_c, flag_z;
  logic [0:0] pend_bank;
  logic [3:0] pend_page;
  logic [7:0] x_ptr;
  logic [3:0] mem_rdata;
  logic       busy;
  logic [0:0] pc_bank;
  logic [3:0] pc_page;
  logic [7:0] pc_step;
  logic [7:0] sp;
  logic [7:0] mem_addr;
  logic       mem_re, mem_we;
  logic [3:0] mem_wdata;
  logic       x_adv;
  logic [7:0] x_next;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  bs_branch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .flag_c(flag_c), .flag_z(flag_z), .pend_bank(pend_bank), .pend_page(pend_page),
    .x_ptr(x_ptr), .mem_rdata(mem_rdata), .busy(busy), .pc_bank(pc_bank),
    .pc_page(pc_page), .pc_step(pc_step), .sp(sp), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .x_adv(x_adv), .x_next(x_next)
  );

  // nibble memory with one-cycle read latency, plus logs
  logic [3:0] mem [256];
  int         wr_n = 0;
  int         rd_n = 0;
  int         xadv_n = 0;
  logic [7:0] xadv_v = '0;
  logic [7:0] wr_a [16];
  logic [3:0] wr_d [16];

  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr]   <= mem_wdata;
      wr_a[wr_n % 16] <= mem_addr;
      wr_d[wr_n % 16] <= mem_wdata;
      wr_n            <= wr_n + 1;
    end
    if (mem_re) begin
      mem_rdata <= mem[mem_addr];
      rd_n      <= rd_n + 1;
    end
    if (x_adv) begin
      xadv_n <= xadv_n + 1;
      xadv_v <= x_next;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_pc(input string req, input logic [0:0] b, input logic [3:0] p, input logic [7:0] s);
    chk({req, " bank"}, 32'(pc_bank), 32'(b));
    chk({req, " page"}, 32'(pc_page), 32'(p));
    chk({req, " step"}, 32'(pc_step), 32'(s));
  endtask

  // present one opcode, wait for the sequence to end; optionally pulse op_valid mid-sequence
  task automatic issue(input logic [11:0] op, input bit inject, output int cyc, output bit moved);
    logic [12:0] pc0;
    @(negedge clk);
    opcode   = op;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    cyc      = 0;
    moved    = 1'b0;
    pc0      = {pc_bank, pc_page, pc_step};
    while (busy) begin
      cyc++;
      if ({pc_bank, pc_page, pc_step} !== pc0) moved = 1'b1;
      if (inject && cyc == 2) begin
        opcode   = 12'h0EE;
        op_valid = 1'b1;
      end else begin
        op_valid = 1'b0;
      end
      @(negedge clk);
    end
    op_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy), 0);
    chk("R1 we", 32'(mem_we), 0);
    chk("R1 re", 32'(mem_re), 0);
    chk("R1 xadv", 32'(x_adv), 0);
    chk("R1 sp", 32'(sp), 0);
    chk_pc("R1", 1'b0, 4'h0, 8'h00);
  endtask

  task automatic t_plain();
    int c; bit m;
    pend_bank = 1'b1; pend_page = 4'h3;
    issue(12'h800, 1'b0, c, m);
    chk("R2 no busy", 32'(c), 0);
    chk_pc("R2 plain", 1'b0, 4'h0, 8'h01);
    chk("R2 sp", 32'(sp), 0);
  endtask

  task automatic t_jump();
    int c; bit m;
    issue(12'h0FF, 1'b0, c, m);
    chk("R3 cycles", 32'(c), 5);
    chk("R11 hold", 32'(m), 0);
    chk_pc("R3 jump", 1'b1, 4'h3, 8'hFF);
    issue(12'hA12, 1'b0, c, m);
    chk_pc("R2 wrap", 1'b1, 4'h3, 8'h00);
  endtask

  task automatic t_cond();
    logic [0:0] eb; logic [3:0] ep; logic [7:0] es;
    eb = pc_bank; ep = pc_page; es = pc_step;
    for (int i = 0; i < 8; i++) begin
      int c; bit m; bit tk; logic [3:0] nib;
      case (i / 2)
        0: nib = 4'h2;
        1: nib = 4'h3;
        2: nib = 4'h6;
        default: nib = 4'h7;
      endcase
      flag_c    = (i % 2 == 1);
      flag_z    = (i % 2 == 0);
      pend_page = 4'(i + 6);
      pend_bank = 1'(i);
      case (nib)
        4'h2: tk = flag_c;
        4'h3: tk = !flag_c;
        4'h6: tk = flag_z;
        default: tk = !flag_z;
      endcase
      issue({nib, 8'(i * 17 + 3)}, 1'b0, c, m);
      if (tk) begin
        eb = pend_bank; ep = pend_page; es = 8'(i * 17 + 3);
      end else begin
        es = es + 8'd1;
      end
      chk("R4 cycles", 32'(c), 5);
      chk_pc("R4 cond", eb, ep, es);
    end
    flag_c = 1'b0; flag_z = 1'b0;
  endtask

  task automatic t_call();
    int c; bit m; int w0;
    pend_bank = 1'b0; pend_page = 4'h2;
    issue(12'h04F, 1'b0, c, m);
    pend_bank = 1'b1; pend_page = 4'h5;
    w0 = wr_n;
    issue(12'h4A7, 1'b1, c, m);
    chk("R5 R9 cycles", 32'(c), 7);
    chk("R11 hold", 32'(m), 0);
    chk_pc("R5 R9 target", 1'b1, 4'h5, 8'hA7);
    chk("R10 sp wrap", 32'(sp), 32'hFD);
    chk("R5 writes", 32'(wr_n - w0), 3);
    chk("R5 w1 addr", 32'(wr_a[w0 % 16]), 32'hFF);
    chk("R5 w1 data", 32'(wr_d[w0 % 16]), 32'h2);
    chk("R5 w2 addr", 32'(wr_a[(w0 + 1) % 16]), 32'hFE);
    chk("R5 w2 data", 32'(wr_d[(w0 + 1) % 16]), 32'h5);
    chk("R5 w3 addr", 32'(wr_a[(w0 + 2) % 16]), 32'hFD);
    chk("R5 w3 data", 32'(wr_d[(w0 + 2) % 16]), 32'h0);
  endtask

  task automatic t_calz();
    int c; bit m; int w0;
    pend_bank = 1'b0; pend_page = 4'h9;
    w0 = wr_n;
    issue(12'h533, 1'b0, c, m);
    chk("R6 cycles", 32'(c), 7);
    chk_pc("R6 target", 1'b0, 4'h0, 8'h33);
    chk("R6 sp", 32'(sp), 32'hFA);
    chk("R6 mem FC", 32'(mem[8'hFC]), 32'h5);
    chk("R6 mem FB", 32'(mem[8'hFB]), 32'hA);
    chk("R6 mem FA", 32'(mem[8'hFA]), 32'h8);
    chk("R6 writes", 32'(wr_n - w0), 3);
  endtask

  task automatic t_retd();
    int c; bit m; int w0, r0, x0;
    pend_bank = 1'b1; pend_page = 4'hE;
    x_ptr = 8'hFF;
    w0 = wr_n; r0 = rd_n; x0 = xadv_n;
    issue(12'h1C4, 1'b0, c, m);
    chk("R7 cycles", 32'(c), 12);
    chk("R11 hold", 32'(m), 0);
    chk_pc("R7 pop", 1'b0, 4'h5, 8'hA8);
    chk("R7 sp", 32'(sp), 32'hFD);
    chk("R7 reads", 32'(rd_n - r0), 3);
    chk("R8 w1 addr", 32'(wr_a[w0 % 16]), 32'hFF);
    chk("R8 w1 data", 32'(wr_d[w0 % 16]), 32'h4);
    chk("R10 R8 w2 addr", 32'(wr_a[(w0 + 1) % 16]), 32'h00);
    chk("R8 w2 data", 32'(wr_d[(w0 + 1) % 16]), 32'hC);
    chk("R8 xadv count", 32'(xadv_n - x0), 1);
    chk("R10 R8 x_next", 32'(xadv_v), 32'h01);
    x_ptr = 8'h20;
    x0 = xadv_n;
    issue(12'h17E, 1'b0, c, m);
    chk_pc("R7 second pop", 1'b0, 4'h4, 8'h50);
    chk("R10 sp wrap up", 32'(sp), 32'h00);
    chk("R8 mem 20", 32'(mem[8'h20]), 32'hE);
    chk("R8 mem 21", 32'(mem[8'h21]), 32'h7);
    chk("R8 x_next", 32'(xadv_v), 32'h22);
    chk("R8 xadv count2", 32'(xadv_n - x0), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 4'h0;
    rst_n = 1'b0; op_valid = 1'b0; opcode = '0;
    flag_c = 1'b0; flag_z = 1'b0;
    pend_bank = '0; pend_page = '0; x_ptr = '0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_jump();
    t_cond();
    t_call();
    t_calz();
    t_retd();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule